// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns single read or write requests from on-chip logic into cycles on an external bus where address and data share one set of wires. It runs from a clock at twice the bus rate. Each clock period is one half of a bus clock, so every strobe edge lands on a half-bus-clock boundary. A cycle opens with the address on the shared wires and the address strobe high. The strobe then falls to latch the address. The read or write strobe follows and stays low for one bus clock plus any wait clocks. The cycle closes with a recovery tail. After a read, an optional idle bus clock can be added.

Wait clocks come from two sources. The first is a per-request programmable count. The second is an external wait input, checked each time the strobe window is about to close. Another bus master can claim the wires through a request/acknowledge pair. Any cycle in progress finishes first. The block then floats every bus output and holds off new requests until the claim is withdrawn.

Top module: `mxb_ctrl`

## Requirements
- R1: A cycle drives the address for one half with `bus_as` high, then one half with `bus_as` low. The strobe falls on the next half. `bus_as` rises one half after the strobe rises and stays high at least two halves before the next fall.
- R2: During a read strobe `bus_ad_oe` is 0. `bus_ad_in` is captured at the edge where `bus_rd_n` rises. `rsp_done` pulses for exactly one clock in the half after the strobe rises, with `rsp_rdata` holding the captured value.
- R3: The strobe is low for 2*(1+n) clocks, where n = `req_wait` (0..3) plus the extra bus clocks added by the wait input. `bus_rd_n` and `bus_wr_n` are never low together.
- R4: On a write, `bus_ad_out` carries the write data with `bus_ad_oe` = 1 during every strobe-low clock and for two clocks after `bus_wr_n` rises.
- R5: `bus_wait` (active high) passes through a two-flop synchronizer. It is checked on the last clock of each strobe window. If it is high there, the window grows by two clocks, so a later check point follows a larger `req_wait`.
- R6: After a read with `req_idle` = 1, two extra clocks pass before `req_ready` returns, so the next address appears five halves after `bus_rd_n` rises instead of three. `req_idle` has no effect on writes.
- R7: `hold_ack` rises only when no cycle is in progress. From an idle bus it rises on the third clock after `hold_req` is raised. While `hold_ack` is 1, `ctl_oe` and `bus_ad_oe` are 0.
- R8: While `hold_ack` is 1, or while a synchronized `hold_req` meets an idle bus, `req_ready` is 0 and no request is accepted. The hold wins over a request pending in the same clock.
- R9: `hold_ack` falls on the third clock after `hold_req` is dropped. The block then accepts the next request and drives the bus again.
- R10: After reset, `bus_as`, `bus_rd_n` and `bus_wr_n` are 1, `ctl_oe` is 1, `bus_ad_oe`, `hold_ack` and `rsp_done` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| req_wait | input | WAIT_W | Programmable wait bus clocks |
| req_idle | input | 1 | Add one idle bus clock after a read |
| rsp_done | output | 1 | One-clock pulse at cycle end |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_ad_out | output | BUS_W | Shared bus output value |
| bus_ad_in | input | BUS_W | Shared bus input value |
| bus_ad_oe | output | 1 | Shared bus output enable |
| bus_as | output | 1 | Address strobe, address latched on fall |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Output enable for the three strobes |
| bus_wait | input | 1 | External wait request, active high |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus released to the external master |

## Verification
Two functions can meet in one clock: a synchronized hold request and a queued transfer request, both pending when the sequencer returns to idle. The bench provokes this by raising `hold_req` during a long read while a second request is held valid. It judges the result by requiring that `req_ready` never rises before `hold_ack`, that no strobe is low while `hold_ack` is high, and that the queued request runs with the correct address once the hold is withdrawn. The remaining timing is swept over every combination of direction, programmable wait, idle option and zero to two external wait clocks. Strobe widths and gaps are computed arithmetically.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADR,
      PH_LAT,
      PH_STB,
      PH_REC1,
      PH_REC2,
      PH_GAP,
      PH_HOLD
   } mxb_phase_e;
endpackage

// File: rtl/mxb_sync.sv
module mxb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
   import mxb_pkg::*;
#(
   parameter int WAIT_W = 2,
   localparam int CNT_W = WAIT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [WAIT_W-1:0] req_wait,
   input  logic              req_idle,
   input  logic              wait_s,
   input  logic              hold_s,
   output logic              accept,
   output mxb_phase_e        phase,
   output logic              wr_q,
   output logic              cap
);
   mxb_phase_e        nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic [WAIT_W-1:0] wait_q;
   logic              idle_q;
   logic              win_end;

   assign accept  = (phase == PH_IDLE) && !hold_s && req_valid;
   assign win_end = (phase == PH_STB) && (cnt_q == '0);
   assign cap     = win_end && !wait_s && !wr_q;

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_IDLE: if (hold_s) nxt = PH_HOLD;
                  else if (req_valid) nxt = PH_ADR;
         PH_ADR:  nxt = PH_LAT;
         PH_LAT:  nxt = PH_STB;
         PH_STB:  if (win_end && !wait_s) nxt = PH_REC1;
         PH_REC1: nxt = PH_REC2;
         PH_REC2: nxt = (!wr_q && idle_q) ? PH_GAP : PH_IDLE;
         PH_GAP:  if (cnt_q == '0) nxt = PH_IDLE;
         PH_HOLD: if (!hold_s) nxt = PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt_q  <= '0;
         wait_q <= '0;
         idle_q <= 1'b0;
         wr_q   <= 1'b0;
      end else begin
         phase <= nxt;
         if (accept) begin
            wr_q   <= req_write;
            wait_q <= req_wait;
            idle_q <= req_idle;
         end
         if (phase == PH_LAT) cnt_q <= {wait_q, 1'b1};
         else if (win_end && wait_s) cnt_q <= CNT_W'(1);
         else if (phase == PH_REC2) cnt_q <= CNT_W'(1);
         else if ((phase == PH_STB || phase == PH_GAP) && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/mxb_dpath.sv
module mxb_dpath #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cap,
   input  logic              drv_addr,
   input  logic [BUS_W-1:0]  bus_in,
   output logic [BUS_W-1:0]  bus_out,
   output logic [DATA_W-1:0] rdata
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         if (load) begin
            addr_q  <= addr;
            wdata_q <= wdata;
         end
         if (cap) rdata <= bus_in[DATA_W-1:0];
      end
   end

   assign bus_out = drv_addr ? BUS_W'(addr_q) : BUS_W'(wdata_q);
endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
   import mxb_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int WAIT_W      = 2,
   parameter int SYNC_STAGES = 2,
   localparam int BUS_W      = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WAIT_W-1:0] req_wait,
   input  logic              req_idle,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [BUS_W-1:0]  bus_ad_out,
   input  logic [BUS_W-1:0]  bus_ad_in,
   output logic              bus_ad_oe,
   output logic              bus_as,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic              ctl_oe,
   input  logic              bus_wait,
   input  logic              hold_req,
   output logic              hold_ack
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mxb_ctrl: SYNC_STAGES must be at least 2");
      end
      if (WAIT_W < 1 || WAIT_W > 6) begin : g_bad_wait
         $error("mxb_ctrl: WAIT_W out of range 1..6");
      end
   endgenerate

   mxb_phase_e phase;
   logic wait_s, hold_s, accept, wr_q, cap, drv_addr;

   mxb_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_wait), .q(wait_s));
   mxb_sync #(.STAGES(SYNC_STAGES)) u_hold_sync (
      .clk(clk), .rst_n(rst_n), .d(hold_req), .q(hold_s));

   mxb_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wait(req_wait), .req_idle(req_idle), .wait_s(wait_s), .hold_s(hold_s),
      .accept(accept), .phase(phase), .wr_q(wr_q), .cap(cap));

   mxb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_dpath (
      .clk(clk), .rst_n(rst_n), .load(accept), .addr(req_addr), .wdata(req_wdata),
      .cap(cap), .drv_addr(drv_addr), .bus_in(bus_ad_in), .bus_out(bus_ad_out),
      .rdata(rsp_rdata));

   assign drv_addr  = (phase == PH_ADR) || (phase == PH_LAT);
   assign req_ready = (phase == PH_IDLE) && !hold_s;
   assign rsp_done  = (phase == PH_REC1);
   assign bus_as    = !((phase == PH_LAT) || (phase == PH_STB) || (phase == PH_REC1));
   assign bus_rd_n  = !((phase == PH_STB) && !wr_q);
   assign bus_wr_n  = !((phase == PH_STB) && wr_q);
   assign bus_ad_oe = drv_addr ||
                      (wr_q && ((phase == PH_STB) || (phase == PH_REC1) || (phase == PH_REC2)));
   assign ctl_oe    = (phase != PH_HOLD);
   assign hold_ack  = (phase == PH_HOLD);

   AST_STB_AFTER_AS: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> (!$past(bus_as) && $past(bus_as, 2))); // R1
   AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_ad_oe); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R2
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n)); // R3
   AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr_n) |-> bus_ad_oe); // R4
   AST_ACK_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(bus_rd_n && bus_wr_n && bus_as)); // R7
   AST_ACK_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> (!ctl_oe && !bus_ad_oe)); // R7
   AST_HELD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> !req_ready); // R8
endmodule

// File: tb/mxb_ctrl_tb.sv
module mxb_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_write = 0, req_idle = 0;
   logic [15:0] req_addr = '0, req_wdata = '0, bus_ad_in = '0;
   logic [1:0] req_wait = '0;
   logic bus_wait = 0, hold_req = 0;
   logic req_ready, rsp_done, bus_ad_oe, bus_as, bus_rd_n, bus_wr_n, ctl_oe, hold_ack;
   logic [15:0] rsp_rdata, bus_ad_out;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mxb_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_wait(req_wait), .req_idle(req_idle), .rsp_done(rsp_done),
      .rsp_rdata(rsp_rdata), .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in),
      .bus_ad_oe(bus_ad_oe), .bus_as(bus_as), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .ctl_oe(ctl_oe), .bus_wait(bus_wait),
      .hold_req(hold_req), .hold_ack(hold_ack));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_cycle(input bit wr, input int w, input bit idl, input int x,
                            input logic [15:0] a, input logic [15:0] d);
      int p, dd, l, g;
      p  = 2 * (1 + w);
      dd = p - 1 + 2 * (x - 1);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      req_wait = 2'(w); req_idle = idl; bus_wait = (x > 0); bus_ad_in = d ^ 16'h3C3C;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      chk(bus_as && bus_ad_oe && bus_ad_out == a && bus_rd_n && bus_wr_n,
          "R1 addr phase", int'(bus_ad_out), int'(a));
      @(negedge clk);
      chk(!bus_as && bus_ad_oe && bus_ad_out == a && bus_rd_n && bus_wr_n,
          "R1 latch phase", int'(bus_as), 0);
      @(negedge clk);
      l = 0;
      while ((wr ? !bus_wr_n : !bus_rd_n) && l < 200) begin
         l++;
         if (wr) chk(bus_ad_oe && bus_ad_out == d, "R4 data in strobe", int'(bus_ad_out), int'(d));
         else    chk(!bus_ad_oe, "R2 float in read", int'(bus_ad_oe), 0);
         if (x > 0 && l == dd) bus_wait = 0;
         @(negedge clk);
      end
      chk(l == p + 2 * x, "R3 strobe width", l, p + 2 * x);
      if (x > 0) chk(l == p + 2 * x, "R5 wait stretch", l, p + 2 * x);
      chk(!bus_as && bus_rd_n && bus_wr_n, "R1 as after strobe", int'(bus_as), 0);
      chk(rsp_done, "R2 done pulse", int'(rsp_done), 1);
      if (wr) chk(bus_ad_oe && bus_ad_out == d, "R4 hold 1", int'(bus_ad_out), int'(d));
      else    chk(rsp_rdata == (d ^ 16'h3C3C), "R2 read data", int'(rsp_rdata), int'(d ^ 16'h3C3C));
      @(negedge clk);
      chk(bus_as && !rsp_done, "R1 as rise", int'(bus_as), 1);
      if (wr) chk(bus_ad_oe && bus_ad_out == d, "R4 hold 2", int'(bus_ad_out), int'(d));
      g = 0;
      @(negedge clk);
      while (!req_ready && g < 50) begin g++; @(negedge clk); end
      chk(g == ((!wr && idl) ? 2 : 0), "R6 post-read idle", g, (!wr && idl) ? 2 : 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int k, kk;
      bit sawready, badstb;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk(bus_as && bus_rd_n && bus_wr_n && ctl_oe, "R10 strobes idle", int'(bus_as), 1);
      chk(!bus_ad_oe && !hold_ack && !rsp_done, "R10 enables", int'(bus_ad_oe), 0);
      chk(req_ready, "R10 ready", int'(req_ready), 1);

      // sweep: direction x wait x idle x external waits
      kk = 0;
      for (int wr = 0; wr < 2; wr++)
         for (int w = 0; w < 4; w++)
            for (int idl = 0; idl < 2; idl++)
               for (int x = 0; x < 3; x++) begin
                  run_cycle(wr[0], w, idl[0], x, 16'(16'h1000 + kk * 37),
                            16'((kk * 8191) ^ 16'hA5A5));
                  kk++;
               end

      // R7/R8/R9 hold from idle bus
      @(negedge clk);
      hold_req = 1;
      k = 0;
      do begin @(negedge clk); k++; end while (!hold_ack && k < 20);
      chk(k == 3, "R7 ack latency", k, 3);
      chk(!ctl_oe && !bus_ad_oe, "R7 float", int'(ctl_oe), 0);
      req_valid = 1; req_write = 0; req_addr = 16'h7777; req_wait = 0; req_idle = 0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk(!req_ready && hold_ack && bus_rd_n, "R8 stall while held", int'(req_ready), 0);
      end
      hold_req = 0;
      k = 0;
      do begin @(negedge clk); k++; end while (hold_ack && k < 20);
      chk(k == 3, "R9 ack release", k, 3);
      chk(ctl_oe && req_ready, "R9 bus back", int'(ctl_oe), 1);
      req_valid = 0;
      run_cycle(1'b0, 1, 1'b0, 0, 16'h2468, 16'h1357);

      // collision: hold arrives during a read while another request is queued
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 16'h4321; req_wait = 2'd3;
      req_idle = 0; bus_ad_in = 16'hBEEF;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      hold_req = 1;
      req_addr = 16'h5A5A;
      sawready = 0; badstb = 0; k = 0;
      while (!hold_ack && k < 60) begin
         if (req_ready) sawready = 1;
         if (rsp_done) chk(rsp_rdata == 16'hBEEF, "R2 read before hold", int'(rsp_rdata), 16'hBEEF);
         @(negedge clk);
         k++;
         if (hold_ack && (!bus_rd_n || !bus_wr_n)) badstb = 1;
      end
      chk(hold_ack, "R7 ack after cycle", int'(hold_ack), 1);
      chk(k >= 11, "R7 waited for cycle", k, 11);
      chk(!sawready, "R8 hold wins over queued request", int'(sawready), 0);
      chk(!badstb, "R7 no strobe under hold", int'(badstb), 0);
      repeat (3) @(negedge clk);
      hold_req = 0;
      k = 0;
      do begin @(negedge clk); k++; end while (hold_ack && k < 20);
      chk(k == 3, "R9 release after collision", k, 3);
      @(negedge clk);
      req_valid = 0;
      chk(bus_as && bus_ad_oe && bus_ad_out == 16'h5A5A, "R9 queued request runs",
          int'(bus_ad_out), 16'h5A5A);
      k = 0;
      while (!rsp_done && k < 60) begin @(negedge clk); k++; end
      chk(rsp_done, "R9 queued request completes", int'(rsp_done), 1);
      repeat (4) @(negedge clk);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule